// File: doc/BRIEF.md
# Sync-Word Gated Receive FIFO

This block sits behind a clock-recovery stage. It takes the recovered serial bits, each one marked by a one-cycle valid strobe, and waits for a programmable synchronisation word before it stores anything. Once the word is found, every following bit is shifted into a small bit-granular FIFO. A byte-wide read port pops the oldest eight bits, with the first received bit in the most significant position. Three flags are raised: an interrupt flag when the stored bit count reaches a programmable level, a sticky overflow flag, and an empty flag.

The sync word is either two bytes (a fixed high byte of 0x2D followed by the programmable low byte `sync_lo`, whose usual value is 0xD4, giving 0x2DD4) or, in short mode, the low byte alone. An always-fill mode skips the sync search. The fill-enable input arms the block. Dropping fill-enable stops storage at once and discards the progress of the search.

The control state machine has three states. IDLE is entered on reset and whenever `fill_en` is low. In IDLE a raised `fill_en` leads to FILL when `fill_always` is high, and to HUNT otherwise. HUNT shifts the incoming bits into a 16-bit detector. It goes to FILL when a match is found, or when `fill_always` is raised, and it returns to IDLE when `fill_en` falls. FILL stores every valid bit and returns to IDLE when `fill_en` falls. The detector and its bit counter are cleared in every state except HUNT.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset, `empty_flag` is 1, `irq_flag` is 0, `ovf_flag` is 0 and `rd_data` is 0x00.
- R2: With `sync_short`=0 and `fill_always`=0, bits are stored only after the 16 most recent valid bits equal {0x2D, `sync_lo`}. The sync bits themselves are not stored. The first stored bit appears at `rd_data[7]`.
- R3: With `sync_short`=1, only the last 8 bits are compared with `sync_lo`, and the other byte is ignored. A match counts only once at least 8 valid bits have been seen since the search began (16 bits in long mode).
- R4: With `fill_always`=1, every valid bit is stored from the first strobe one cycle after `fill_en` rises, with no match needed.
- R5: When `fill_en` is low, no bit is stored and the held data does not change. Raising `fill_en` again in sync-gated mode requires a fresh, complete sync match.
- R6: When `rd_pop` is high and at least 8 bits are held, the oldest 8 bits are removed. With fewer than 8 bits held, `rd_pop` removes nothing.
- R7: `irq_flag` is set after a stored bit makes the held count greater than or equal to `irq_level`. It is cleared after any `rd_pop` cycle in which no such bit is stored.
- R8: A valid bit that arrives in FILL while 16 bits are held, and no byte is popped in the same cycle, is dropped. It sets `ovf_flag`, which stays set until a `stat_rd` cycle in which no new overflow occurs.
- R9: `empty_flag` is 1 exactly when no bit is held.
- R10: `rd_data` shows the oldest 8 bits when 8 or more bits are held, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered serial data bit |
| bit_vld | input | 1 | One-cycle strobe qualifying `bit_in` |
| fill_en | input | 1 | Arms the search and storage; low stops both |
| fill_always | input | 1 | 1: store without a sync match |
| sync_short | input | 1 | 1: one-byte sync word (`sync_lo` only) |
| sync_lo | input | 8 | Programmable low sync byte |
| irq_level | input | 4 | Held-bit count that raises `irq_flag` |
| rd_pop | input | 1 | Pop the oldest byte |
| stat_rd | input | 1 | Status read; clears `ovf_flag` |
| rd_data | output | 8 | Oldest byte, first received bit in bit 7 |
| irq_flag | output | 1 | Bit-count threshold reached |
| ovf_flag | output | 1 | Sticky data-lost flag |
| empty_flag | output | 1 | No bits held |

## Verification
The state machine's state is not visible at the ports, so a wrong state shows up in the data. A match found too early, or against the wrong bytes, puts sync bits or shifted data into `rd_data` as soon as the first byte completes. A detector that is not cleared when `fill_en` falls lets data in without a fresh sync word, and the next popped byte is corrupt. A wrong held count shows within one strobe, as a misplaced `empty_flag` or `irq_flag` edge, a missing overflow at the seventeenth bit, or a pop accepted with fewer than eight bits held.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_FILL
    } hunt_state_t;
endpackage

// File: rtl/sync_hunter.sv
module sync_hunter
    import sync_rx_pkg::*;
#(
    parameter int                BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] SYNC_HI = 'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              fill_en,
    input  logic              fill_always,
    input  logic              sync_short,
    input  logic [BYTE_W-1:0] sync_lo,
    output logic              push_req
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SEEN_W = $clog2(WORD_W + 1);

    hunt_state_t       state_q, state_d;
    logic [WORD_W-1:0] shreg_q, shift_nxt;
    logic [SEEN_W-1:0] seen_q, seen_inc, need;
    logic              word_eq, hit;

    // detector datapath
    always_comb begin
        shift_nxt = {shreg_q[WORD_W-2:0], bit_in};
        seen_inc  = (seen_q == SEEN_W'(WORD_W)) ? seen_q : seen_q + 1'b1;
        need      = sync_short ? SEEN_W'(BYTE_W) : SEEN_W'(WORD_W);
        word_eq   = sync_short ? (shift_nxt[BYTE_W-1:0] == sync_lo)
                               : (shift_nxt == {SYNC_HI, sync_lo});
        hit       = bit_vld && (seen_inc >= need) && word_eq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_HUNT) begin
            shreg_q <= '0;
            seen_q  <= '0;
        end else if (bit_vld) begin
            shreg_q <= shift_nxt;
            seen_q  <= seen_inc;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        push_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fill_en) state_d = fill_always ? ST_FILL : ST_HUNT;
            end
            ST_HUNT: begin
                if (!fill_en)                state_d = ST_IDLE;
                else if (fill_always || hit) state_d = ST_FILL;
            end
            ST_FILL: begin
                push_req = fill_en && bit_vld;
                if (!fill_en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rx_bit_store.sv
module rx_bit_store #(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_req,
    input  logic                       bit_in,
    input  logic                       rd_pop,
    output logic                       push_ok,
    output logic                       drop,
    output logic [$clog2(DEPTH+1)-1:0] cnt_q,
    output logic [$clog2(DEPTH+1)-1:0] cnt_d,
    output logic [BYTE_W-1:0]          rd_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] mem_q, mem_d;
    logic [CNT_W-1:0] base;
    logic             pop_ok, have_byte;

    assign have_byte = (cnt_q >= CNT_W'(BYTE_W));

    always_comb begin
        pop_ok  = rd_pop && have_byte;
        base    = pop_ok ? cnt_q - CNT_W'(BYTE_W) : cnt_q;
        push_ok = push_req && (base < CNT_W'(DEPTH));
        drop    = push_req && !(base < CNT_W'(DEPTH));
        mem_d   = pop_ok ? (mem_q >> BYTE_W) : mem_q;
        if (push_ok) mem_d[base[IDX_W-1:0]] = bit_in;
        cnt_d   = base + CNT_W'(push_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            cnt_q <= cnt_d;
        end
    end

    // index 0 holds the oldest bit, shown in the MSB
    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_rd
        assign rd_data[BYTE_W-1-gi] = have_byte & mem_q[gi];
    end
endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_ok,
    input  logic                       drop,
    input  logic                       rd_pop,
    input  logic                       stat_rd,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_q,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_d,
    input  logic [$clog2(DEPTH)-1:0]   irq_level,
    output logic                       irq_flag,
    output logic                       ovf_flag,
    output logic                       empty_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic irq_q, ovf_q, lvl_hit;

    assign lvl_hit = push_ok && (cnt_d >= CNT_W'(irq_level));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (lvl_hit)     irq_q <= 1'b1;
            else if (rd_pop) irq_q <= 1'b0;
            if (drop)         ovf_q <= 1'b1;
            else if (stat_rd) ovf_q <= 1'b0;
        end
    end

    assign irq_flag   = irq_q;
    assign ovf_flag   = ovf_q;
    assign empty_flag = (cnt_q == '0);
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
    parameter int                DEPTH   = 16,
    parameter int                BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] SYNC_HI = 'h2D,
    localparam int               LVL_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              fill_en,
    input  logic              fill_always,
    input  logic              sync_short,
    input  logic [BYTE_W-1:0] sync_lo,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              rd_pop,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq_flag,
    output logic              ovf_flag,
    output logic              empty_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_req, push_ok, drop;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    sync_hunter #(.BYTE_W(BYTE_W), .SYNC_HI(SYNC_HI)) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .fill_en    (fill_en),
        .fill_always(fill_always),
        .sync_short (sync_short),
        .sync_lo    (sync_lo),
        .push_req   (push_req)
    );

    rx_bit_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_req(push_req),
        .bit_in  (bit_in),
        .rd_pop  (rd_pop),
        .push_ok (push_ok),
        .drop    (drop),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d),
        .rd_data (rd_data)
    );

    rx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_ok   (push_ok),
        .drop      (drop),
        .rd_pop    (rd_pop),
        .stat_rd   (stat_rd),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .irq_level (irq_level),
        .irq_flag  (irq_flag),
        .ovf_flag  (ovf_flag),
        .empty_flag(empty_flag)
    );
endmodule

// File: rtl/sync_rx_fifo_chk.sv
module sync_rx_fifo_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              fill_en,
    input logic              rd_pop,
    input logic              stat_rd,
    input logic [BYTE_W-1:0] rd_data,
    input logic              irq_flag,
    input logic              ovf_flag,
    input logic              empty_flag
);
    p_empty_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty_flag |-> rd_data == '0);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !stat_rd |=> ovf_flag);

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !bit_vld |=> !ovf_flag);

    p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> !empty_flag);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop && !bit_vld |=> !irq_flag);

    p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en && !rd_pop |=> $stable(rd_data) && $stable(empty_flag));

    p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_flag && !bit_vld |=> empty_flag);
endmodule

bind sync_rx_fifo sync_rx_fifo_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .fill_en   (fill_en),
    .rd_pop    (rd_pop),
    .stat_rd   (stat_rd),
    .rd_data   (rd_data),
    .irq_flag  (irq_flag),
    .ovf_flag  (ovf_flag),
    .empty_flag(empty_flag)
);

// File: tb/sync_rx_fifo_tb.sv
`timescale 1ns/1ps
module sync_rx_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0, bit_vld = 1'b0, fill_en = 1'b0;
    logic       fill_always = 1'b0, sync_short = 1'b0;
    logic [7:0] sync_lo = 8'hD4;
    logic [3:0] irq_level = 4'd15;
    logic       rd_pop = 1'b0, stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq_flag, ovf_flag, empty_flag;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    sync_rx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .fill_en(fill_en), .fill_always(fill_always), .sync_short(sync_short),
        .sync_lo(sync_lo), .irq_level(irq_level), .rd_pop(rd_pop),
        .stat_rd(stat_rd), .rd_data(rd_data), .irq_flag(irq_flag),
        .ovf_flag(ovf_flag), .empty_flag(empty_flag)
    );

    // {short, always, lo[8], nbits[6], stream[32] MSB first, nbytes[2], b0, b1}
    localparam int VW = 66;
    localparam int NV = 7;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'hD4, 6'd32, 32'h2DD4A53C, 2'd2, 8'hA5, 8'h3C}, // R2
        {1'b1, 1'b0, 8'hD4, 6'd24, 32'h37D43C00, 2'd1, 8'h3C, 8'h00}, // R3
        {1'b1, 1'b0, 8'hD4, 6'd24, 32'hAAD45A00, 2'd1, 8'h5A, 8'h00}, // R3
        {1'b0, 1'b0, 8'hD4, 6'd24, 32'hAAD45A00, 2'd0, 8'h00, 8'h00}, // R2
        {1'b0, 1'b0, 8'h96, 6'd24, 32'h2D96C300, 2'd1, 8'hC3, 8'h00}, // R2
        {1'b0, 1'b1, 8'hD4, 6'd16, 32'h5E810000, 2'd2, 8'h5E, 8'h81}, // R4
        {1'b0, 1'b1, 8'hD4, 6'd8,  32'hC7000000, 2'd1, 8'hC7, 8'h00}  // R4
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fill_en = 1'b0; bit_vld = 1'b0; rd_pop = 1'b0; stat_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b; bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] s, input int n);
        for (int i = 0; i < n; i++) send_bit(s[31-i]);
    endtask

    task automatic pop_byte(output logic [7:0] d);
        @(negedge clk);
        d = rd_data; rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic arm(input logic sh, input logic al, input logic [7:0] lo);
        sync_short = sh; fill_always = al; sync_lo = lo;
        fill_en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        do_reset();
        // R1 reset state
        chk("R1 empty", 16'(empty_flag), 16'd1);
        chk("R1 irq",   16'(irq_flag),   16'd0);
        chk("R1 ovf",   16'(ovf_flag),   16'd0);
        chk("R1 data",  16'(rd_data),    16'h00);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            do_reset();
            irq_level = 4'd15;
            arm(e[65], e[64], e[63:56]);
            send_bits(e[49:18], int'(e[55:50]));
            if (e[17:16] >= 2'd1) begin
                pop_byte(d);
                chk($sformatf("R2/R3/R4 vec%0d byte0", v), 16'(d), 16'(e[15:8]));
            end
            if (e[17:16] >= 2'd2) begin
                pop_byte(d);
                chk($sformatf("R2/R4 vec%0d byte1", v), 16'(d), 16'(e[7:0]));
            end
            chk($sformatf("R9 vec%0d empty", v), 16'(empty_flag), 16'd1);
            chk($sformatf("R8 vec%0d ovf", v), 16'(ovf_flag), 16'd0);
        end

        // R3: short zero sync needs 8 bits seen
        do_reset();
        arm(1'b1, 1'b0, 8'h00);
        send_bits(32'h00B70000, 16);
        pop_byte(d);
        chk("R3 zero sync count", 16'(d), 16'hB7);

        // R7 / R6 / R10: threshold, partial pop ignored
        do_reset();
        irq_level = 4'd5;
        arm(1'b0, 1'b1, 8'hD4);
        send_bits(32'hB0000000, 4);
        chk("R7 below level", 16'(irq_flag), 16'd0);
        send_bit(1'b0);
        chk("R7 at level", 16'(irq_flag), 16'd1);
        chk("R10 partial data", 16'(rd_data), 16'h00);
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        chk("R7 read clears", 16'(irq_flag), 16'd0);
        chk("R6 partial pop kept", 16'(empty_flag), 16'd0);
        send_bits(32'hC0000000, 3);
        chk("R7 reached again", 16'(irq_flag), 16'd1);
        pop_byte(d);
        chk("R6 byte after partial pop", 16'(d), 16'hB6);
        chk("R9 empty after pop", 16'(empty_flag), 16'd1);

        // R8 overflow
        do_reset();
        irq_level = 4'd15;
        arm(1'b0, 1'b1, 8'hD4);
        send_bits(32'hA55A0000, 16);
        chk("R8 full no ovf", 16'(ovf_flag), 16'd0);
        send_bit(1'b1);
        chk("R8 ovf set", 16'(ovf_flag), 16'd1);
        fill_en = 1'b0;
        pop_byte(d);
        chk("R8 byte0", 16'(d), 16'hA5);
        pop_byte(d);
        chk("R8 byte1 dropped bit", 16'(d), 16'h5A);
        chk("R8 dropped empty", 16'(empty_flag), 16'd1);
        chk("R8 sticky", 16'(ovf_flag), 16'd1);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R8 status clears", 16'(ovf_flag), 16'd0);

        // R5 fill-enable drop
        do_reset();
        arm(1'b0, 1'b0, 8'hD4);
        send_bits(32'h2DD49000, 20);
        @(negedge clk); fill_en = 1'b0;
        @(negedge clk);
        send_bits(32'hF0000000, 4);
        chk("R5 held while off", 16'(empty_flag), 16'd0);
        fill_en = 1'b1;
        @(negedge clk);
        send_bits(32'hF0000000, 8);
        send_bits(32'h2DD46000, 20);
        pop_byte(d);
        chk("R5 fresh sync byte", 16'(d), 16'h96);
        chk("R5 empty", 16'(empty_flag), 16'd1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule